// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block derives a serial audio bit clock and a periodic frame-sync pulse from the system clock. It is used when the audio port drives its own clocks. The system clock is divided by a programmable ratio to form each bit period. A frame sequencer counts bit periods to build frames whose length, pulse width and pulse polarity are programmable. The length and the width are each written as the count of bit periods minus one.

A control state machine brings the two generators out of reset in a fixed order. It has three states. In `CS_HALT` both generators are held. In `CS_CLK` only the divider runs. In `CS_FRAME` the divider and the frame sequencer both run. `CS_HALT` goes to `CS_CLK` when the clock enable is high, the port drives the bit clock and stop is low. `CS_CLK` goes to `CS_FRAME` when the frame enable is high and the port drives frame sync. `CS_FRAME` falls back to `CS_CLK` when either of those drops. `CS_CLK` and `CS_FRAME` fall to `CS_HALT` on stop, or when the clock enable or the clock drive select drops.

The frame sequencer has its own machine with three states. `FS_IDLE` is the state while the frame generator is held. The first bit-period end while running moves it to `FS_PULSE`, and bit index 0 begins there. At each later bit-period end it moves to `FS_PULSE` or `FS_GAP`, depending on where the new bit index falls in the frame. Configuration is copied into shadow registers only while the matching generator is held in reset.

Top module: `aud_clkfs_gen`

## Requirements
- R1: With divider value D, `bclk_tick_o` is high for one cycle every D+1 cycles. The first tick is in the first cycle the clock generator runs. `bclk_o` is high for the first (D+2)/2 cycles of each period (integer division), so D=0 keeps it high.
- R2: The clock generator starts running in the cycle after the clock enable is seen high with the clock drive select high and stop low. While the generator is held, `bclk_o` and `bclk_tick_o` are 0.
- R3: The frame generator runs only after the clock generator has run for at least one cycle. A frame enable raised while the clock generator is held produces no frame sync. If the frame enable is already high, the frame generator starts one cycle after the clock generator.
- R4: The first frame begins at the first bit-period start that falls strictly after the first cycle in which the frame generator runs.
- R5: With frame field F and width field W, a frame lasts F+1 bit periods. Frame sync is active during the first W+1 bit periods of each frame, and during the whole frame when W is at least F.
- R6: When the polarity bit is 0, active frame sync drives `fsync_o` to 1. When it is 1, active drives 0. While the frame generator is held, `fsync_o` shows the inactive level.
- R7: Stop puts both generators into reset in the next cycle and overrides both enables. After stop is released, the clock restarts at the start of a bit period.
- R8: Dropping the frame enable makes frame sync inactive in the next cycle. Raising it again restarts the frame count from bit 0, following R4.
- R9: The divider value is taken only while the clock generator is held. The frame, width and polarity fields are taken only while the frame generator is held. Changes made while a generator runs have no effect on that generator.
- R10: With the clock drive select low, both generators stay held. With the frame drive select low, the frame generator stays held while the clock runs.
- R11: `fsync_o` changes only in cycles in which `bclk_tick_o` is high, while the frame generator keeps running.
- R12: The frame field is 12 bits wide, so frames of up to 4096 bit periods work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_bclk_i | input | 1 | Port is configured to drive the bit clock |
| drv_fsync_i | input | 1 | Port is configured to drive frame sync |
| bclk_div_i | input | DIV_W (8) | Divider value; bit period is this plus one system cycles |
| frame_len_i | input | FPER_W (12) | Bit periods per frame minus one |
| pulse_len_i | input | FWID_W (8) | Bit periods of active frame sync minus one |
| fsync_inv_i | input | 1 | Frame-sync polarity: 0 active high, 1 active low |
| bclk_gen_en_i | input | 1 | Releases the clock generator from reset |
| fsync_gen_en_i | input | 1 | Releases the frame generator from reset |
| stop_i | input | 1 | Holds both generators in reset |
| bclk_o | output | 1 | Bit-clock level |
| bclk_tick_o | output | 1 | One-cycle mark at the start of each bit period |
| fsync_o | output | 1 | Frame-sync level |

## Verification
The assertions assume that the frame and width fields stay stable while their generator runs only through the shadow copies, not at the pins. They also assume that stop, the enables and the drive selects are synchronous to the system clock. The stimulus changes every input half a cycle away from the active edge. It writes configuration only while the generators are held, except in the one sequence that deliberately writes new values mid-run to show they are ignored. Expected tick, level and frame-sync values come from arithmetic on the cycle index since start-up. That arithmetic is swept over several divider values, frame shapes, polarities and enable delays.

// File: rtl/aud_clkfs_pkg.sv
package aud_clkfs_pkg;

    typedef enum logic [1:0] {
        CS_HALT  = 2'd0,
        CS_CLK   = 2'd1,
        CS_FRAME = 2'd2
    } ctrl_state_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_PULSE = 2'd1,
        FS_GAP   = 2'd2
    } fs_state_e;

endpackage

// File: rtl/aud_gen_ctrl.sv
module aud_gen_ctrl
    import aud_clkfs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic drv_bclk_i,
    input  logic drv_fsync_i,
    input  logic bclk_gen_en_i,
    input  logic fsync_gen_en_i,
    input  logic stop_i,
    output logic clk_run_o,
    output logic fs_run_o,
    output logic clk_load_o,
    output logic fs_load_o
);

    ctrl_state_e state_q, state_d;
    logic        clk_ok, fs_ok;

    assign clk_ok = bclk_gen_en_i && drv_bclk_i && !stop_i;
    assign fs_ok  = fsync_gen_en_i && drv_fsync_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CS_HALT;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALT: begin
                if (clk_ok) state_d = CS_CLK;
            end
            CS_CLK: begin
                if (!clk_ok)    state_d = CS_HALT;
                else if (fs_ok) state_d = CS_FRAME;
            end
            CS_FRAME: begin
                if (!clk_ok)     state_d = CS_HALT;
                else if (!fs_ok) state_d = CS_CLK;
            end
            default: state_d = CS_HALT;
        endcase
    end

    always_comb begin
        clk_run_o  = (state_q != CS_HALT);
        fs_run_o   = (state_q == CS_FRAME);
        clk_load_o = (state_q == CS_HALT);
        fs_load_o  = (state_q != CS_FRAME);
    end

    AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (state_q == CS_HALT)); // R7
    AST_FRAME_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CS_FRAME) |-> ($past(state_q) != CS_HALT)); // R3
    AST_NODRIVE_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_bclk_i |=> (state_q == CS_HALT)); // R10

endmodule

// File: rtl/aud_bclk_div.sv
module aud_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             wrap_o,
    output logic             bclk_o
);

    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [CW-1:0]    hi_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (load_i) div_q <= div_i;
    end

    assign hi_len = (CW'(div_q) + CW'(2)) >> 1;

    always_comb begin
        if (!run_i)              cnt_d = '0;
        else if (cnt_q == div_q) cnt_d = '0;
        else                     cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    always_comb begin
        tick_o = run_i && (cnt_q == '0);
        wrap_o = run_i && (cnt_q == div_q);
        bclk_o = run_i && (CW'(cnt_q) < hi_len);
    end

    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q <= div_q)); // R1
    AST_FIRST_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> tick_o); // R2
    AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i)) |-> $stable(div_q)); // R9

endmodule

// File: rtl/aud_fsync_seq.sv
module aud_fsync_seq
    import aud_clkfs_pkg::*;
#(
    parameter int FPER_W = 12,
    parameter int FWID_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              load_i,
    input  logic              wrap_i,
    input  logic              tick_i,
    input  logic [FPER_W-1:0] fper_i,
    input  logic [FWID_W-1:0] fwid_i,
    input  logic              pol_i,
    output logic              fs_o
);

    localparam int CMP_W = (FPER_W > FWID_W) ? FPER_W : FWID_W;

    logic [FPER_W-1:0] fper_q;
    logic [FWID_W-1:0] fwid_q;
    logic              pol_q;
    fs_state_e         st_q, st_d;
    logic [FPER_W-1:0] idx_q, idx_d, step;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fper_q <= '0;
            fwid_q <= '0;
            pol_q  <= 1'b0;
        end else if (load_i) begin
            fper_q <= fper_i;
            fwid_q <= fwid_i;
            pol_q  <= pol_i;
        end
    end

    assign step = (idx_q == fper_q) ? '0 : idx_q + FPER_W'(1);

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (!run_i) begin
            st_d  = FS_IDLE;
            idx_d = '0;
        end else if (wrap_i) begin
            unique case (st_q)
                FS_IDLE: begin
                    st_d  = FS_PULSE;
                    idx_d = '0;
                end
                FS_PULSE, FS_GAP: begin
                    idx_d = step;
                    st_d  = (CMP_W'(step) <= CMP_W'(fwid_q)) ? FS_PULSE : FS_GAP;
                end
                default: begin
                    st_d  = FS_IDLE;
                    idx_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= FS_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        fs_o = pol_q ^ (run_i && (st_q == FS_PULSE));
    end

    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (idx_q <= fper_q)); // R5
    AST_FS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && !$stable(fs_o)) |-> tick_i); // R11
    AST_FRAME_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i)) |-> ($stable(fper_q) && $stable(fwid_q) && $stable(pol_q))); // R9
    AST_FIRST_FRAME_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> (fs_o == pol_q)); // R4

endmodule

// File: rtl/aud_clkfs_gen.sv
module aud_clkfs_gen #(
    parameter int DIV_W  = 8,
    parameter int FPER_W = 12,
    parameter int FWID_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              drv_bclk_i,
    input  logic              drv_fsync_i,
    input  logic [DIV_W-1:0]  bclk_div_i,
    input  logic [FPER_W-1:0] frame_len_i,
    input  logic [FWID_W-1:0] pulse_len_i,
    input  logic              fsync_inv_i,
    input  logic              bclk_gen_en_i,
    input  logic              fsync_gen_en_i,
    input  logic              stop_i,
    output logic              bclk_o,
    output logic              bclk_tick_o,
    output logic              fsync_o
);

    logic clk_run, fs_run, clk_load, fs_load, wrap;

    aud_gen_ctrl u_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .drv_bclk_i     (drv_bclk_i),
        .drv_fsync_i    (drv_fsync_i),
        .bclk_gen_en_i  (bclk_gen_en_i),
        .fsync_gen_en_i (fsync_gen_en_i),
        .stop_i         (stop_i),
        .clk_run_o      (clk_run),
        .fs_run_o       (fs_run),
        .clk_load_o     (clk_load),
        .fs_load_o      (fs_load)
    );

    aud_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (clk_run),
        .load_i (clk_load),
        .div_i  (bclk_div_i),
        .tick_o (bclk_tick_o),
        .wrap_o (wrap),
        .bclk_o (bclk_o)
    );

    aud_fsync_seq #(.FPER_W(FPER_W), .FWID_W(FWID_W)) u_fs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (fs_run),
        .load_i (fs_load),
        .wrap_i (wrap),
        .tick_i (bclk_tick_o),
        .fper_i (frame_len_i),
        .fwid_i (pulse_len_i),
        .pol_i  (fsync_inv_i),
        .fs_o   (fsync_o)
    );

endmodule

// File: tb/tb_aud_clkfs_gen.sv
module tb_aud_clkfs_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NEVER = 1 << 30;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        drv_bclk = 1'b1, drv_fsync = 1'b1;
    logic [7:0]  div_v = '0;
    logic [11:0] flen = '0;
    logic [7:0]  plen = '0;
    logic        inv = 1'b0;
    logic        cen = 1'b0, fen = 1'b0, stop = 1'b0;
    logic        bclk, tick, fsync;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_clkfs_gen dut (
        .clk_i(clk), .rst_ni(rst_ni), .drv_bclk_i(drv_bclk), .drv_fsync_i(drv_fsync),
        .bclk_div_i(div_v), .frame_len_i(flen), .pulse_len_i(plen), .fsync_inv_i(inv),
        .bclk_gen_en_i(cen), .fsync_gen_en_i(fen), .stop_i(stop),
        .bclk_o(bclk), .bclk_tick_o(tick), .fsync_o(fsync)
    );

    task automatic chk(string req, string what, int cyc, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s cycle %0d: got %0b expected %0b", req, what, cyc, got, exp);
        end
    endtask

    function automatic logic exp_fs(int i, int p, int f, int w, logic pol,
                                    int j0, int joff, int jon, bit allowed);
        int a = -1;
        int s;
        logic act;
        if (allowed) begin
            if (i >= jon) a = jon;
            else if (i >= j0 && i < joff) a = j0;
        end
        if (a < 0) return pol;
        s = (a / p + 1) * p;
        act = (i >= s) && ((((i - s) / p) % f) <= w);
        return pol ^ act;
    endfunction

    task automatic idle_gen();
        cen = 1'b0; fen = 1'b0; stop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Called at a negedge with configuration already applied.
    task automatic run_tl(string req, int d, int f, int w, logic pol, int j0, int joff,
                          int jon, int ncyc, int scramble_at, bit allowed);
        int p = d + 1;
        cen = 1'b1;
        if (j0 == 0) fen = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            chk(req, "bclk_tick_o", i, tick, (i % p) == 0);
            chk(req, "bclk_o", i, bclk, (i % p) < ((p + 1) / 2));
            chk(req, "fsync_o", i, fsync, exp_fs(i, p, f + 1, w, pol, j0, joff, jon, allowed));
            if (i == j0 - 1)   fen = 1'b1;
            if (i == joff - 1) fen = 1'b0;
            if (i == jon - 1)  fen = 1'b1;
            if (i == scramble_at) begin
                div_v = div_v ^ 8'h05;
                flen  = 12'd1;
                plen  = 8'd9;
                inv   = ~inv;
            end
        end
    endtask

    task automatic cfg(int d, int f, int w, logic pol);
        div_v = 8'(d); flen = 12'(f); plen = 8'(w); inv = pol;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int dl[4] = '{0, 1, 2, 4};
        int fl[4] = '{3, 7, 4, 2};
        int wl[4] = '{0, 3, 4, 6};
        repeat (3) @(negedge clk);
        // R2 R6 reset state
        chk("R2", "bclk_o reset", 0, bclk, 1'b0);
        chk("R2", "bclk_tick_o reset", 0, tick, 1'b0);
        chk("R6", "fsync_o reset", 0, fsync, 1'b0);
        rst_ni = 1'b1;
        @(negedge clk);

        // R1 R4 R5 R6 sweep
        foreach (dl[a]) foreach (fl[b]) for (int pol = 0; pol < 2; pol++)
            for (int jj = 0; jj < 2; jj++) begin
                int j0 = (jj == 0) ? 1 : 3;
                int p = dl[a] + 1;
                idle_gen();
                cfg(dl[a], fl[b], wl[b], logic'(pol));
                run_tl("R5", dl[a], fl[b], wl[b], logic'(pol), j0, NEVER, NEVER,
                       p * (fl[b] + 1) * 2 + 2 * p + j0 + 3, -1, 1'b1);
            end

        // R3 frame enable before clock enable
        idle_gen();
        cfg(1, 3, 1, 1'b0);
        fen = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R3", "bclk_tick_o held", k, tick, 1'b0);
            chk("R3", "fsync_o held", k, fsync, 1'b0);
        end
        run_tl("R3", 1, 3, 1, 1'b0, 1, NEVER, NEVER, 30, -1, 1'b1);

        // R9 configuration written mid-run is ignored
        idle_gen();
        cfg(2, 5, 1, 1'b0);
        run_tl("R9", 2, 5, 1, 1'b0, 2, NEVER, NEVER, 70, 10, 1'b1);

        // R8 frame enable dropped and raised again
        idle_gen();
        cfg(1, 3, 1, 1'b1);
        run_tl("R8", 1, 3, 1, 1'b1, 1, 11, 16, 50, -1, 1'b1);

        // R7 stop overrides enables, then restart
        idle_gen();
        cfg(2, 3, 0, 1'b1);
        run_tl("R7", 2, 3, 0, 1'b1, 1, NEVER, NEVER, 20, -1, 1'b1);
        stop = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R7", "bclk_o stopped", k, bclk, 1'b0);
            chk("R7", "bclk_tick_o stopped", k, tick, 1'b0);
            chk("R7", "fsync_o stopped", k, fsync, 1'b1);
        end
        stop = 1'b0; fen = 1'b0;
        run_tl("R7", 2, 3, 0, 1'b1, 2, NEVER, NEVER, 30, -1, 1'b1);

        // R10 drive selects
        idle_gen();
        cfg(1, 3, 1, 1'b0);
        drv_bclk = 1'b0;
        cen = 1'b1; fen = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R10", "bclk_o not driven", k, bclk, 1'b0);
            chk("R10", "bclk_tick_o not driven", k, tick, 1'b0);
            chk("R10", "fsync_o not driven", k, fsync, 1'b0);
        end
        drv_bclk = 1'b1;
        idle_gen();
        drv_fsync = 1'b0;
        run_tl("R10", 1, 3, 1, 1'b0, 1, NEVER, NEVER, 30, -1, 1'b0);
        drv_fsync = 1'b1;

        // R12 longest frame
        idle_gen();
        cfg(0, 4095, 15, 1'b1);
        run_tl("R12", 0, 4095, 15, 1'b1, 2, NEVER, NEVER, 4096 * 2 + 8, -1, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule